// File: doc/BRIEF.md
# Tuner Synthesizer Control Slave on I2C

This block is a two-wire serial slave that sets up a tuner frequency synthesizer and reports its condition. A system clock oversamples the clock and data lines. The block drives the data line only through an open-drain pull-low enable. Two select pins choose its 7-bit bus address from a fixed 5-bit prefix, so several synthesizers can share one bus.

**Write transfers.** Data bytes arrive in pairs. The top bit of the first byte of each pair picks the destination:

- When that bit is 0, the pair loads the 15-bit divider ratio.
- When that bit is 1, the first byte sets the loop-control bits and the second byte sets five port enables.

Pairs can follow one another in one transfer until a STOP. A byte that is cut off part-way changes nothing.

**Read transfers.** A read returns a status byte. The block sends it again for as long as the master acknowledges. A sticky power-on flag in the status is cleared by the STOP that closes a read.

All outputs are plain register levels. No stream handshake is involved, so there is no back-pressure: the bus master sets the pace. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `synth_ctl_i2c`

## Requirements
- R1: After reset, `div_ratio`, every control output and `port_en` are 0, `sda_oe` is 0, and the power-on flag reads 1.
- R2: The slave answers only address {5'b11000, addr_sel}. The LSB of the address byte is 0 for write and 1 for read. On a match it pulls SDA low in the ACK slot. On a mismatch it leaves SDA released for the whole transfer.
- R3: In a write, a first-of-pair byte with bit 7 = 0 starts a frequency pair. After the second byte, `div_ratio` = {first[6:0], second[7:0]}. A frequency pair does not touch the control bits or the port enables.
- R4: A first-of-pair byte with bit 7 = 1 is a control byte, applied when the byte is accepted: bit 6 → `cp_hi`, bit 5 → `test_en`, bit 4 → `pump_off`, bits 3:1 → `test_sel[2:0]`, bit 0 → `amp_off`.
- R5: The byte that follows a control byte sets `port_en` = byte[4:0], where bit 0 is port P3 and bit 4 is port P7. A 1 turns the port on.
- R6: Every data byte of a write is acknowledged. Any number of pairs may follow in one transfer without re-addressing. START and STOP reset the pairing to expect a first byte.
- R7: If a STOP cuts a byte off before its eighth bit, no register changes.
- R8: In a read, the status byte is sent again after each master ACK. After a master NACK the slave releases SDA and ignores the bus until the next START.
- R9: The status byte, MSB first, is: power-on flag, `lock_i`, `port_lvl[2]` (P7), `port_lvl[1]` (P5), `port_lvl[0]` (P4), then `adc_code[2:0]`.
- R10: The power-on flag clears on a STOP that ends a read transfer. A STOP that ends a write transfer leaves it set.
- R11: A `por_event` pulse clears `div_ratio`, all control bits and `port_en`, and sets the power-on flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Low two bits of the slave address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| lock_i | input | 1 | Synthesizer lock indication |
| port_lvl | input | 3 | Levels of ports P7, P5, P4 (bits 2,1,0) |
| adc_code | input | 3 | Code from the tuning-error converter |
| por_event | input | 1 | One-cycle power-on-reset event |
| div_ratio | output | 15 | Programmable divider ratio |
| cp_hi | output | 1 | Charge pump high current |
| test_en | output | 1 | Test mode enable |
| pump_off | output | 1 | Charge pump disable |
| test_sel | output | 3 | Test select; bit 0 also picks the reference divider |
| amp_off | output | 1 | Drive amplifier output off |
| port_en | output | 5 | Port enables, bit 0 = P3 … bit 4 = P7 |

## Verification
The bench builds the block with a three-stage input synchronizer, one stage deeper than the default. This checks that the bit timing still holds when line edges are seen later, in particular that the ACK pull-low and each read bit settle well before the master samples. The default address prefix is kept. The bench moves `addr_sel` during the run, so both match and mismatch cases are covered on two distinct addresses.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WR,
    S_WR_ACK,
    S_RD,
    S_RD_ACK
  } slv_state_t;

  typedef struct packed {
    logic       cp;
    logic       t1;
    logic       t0;
    logic [2:0] ts;
    logic       os;
  } ctl_word_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sr, sda_sr;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[DEPTH-2:0], scl_i};
      sda_sr <= {sda_sr[DEPTH-2:0], sda_i};
    end
  end

  assign scl_now   = scl_sr[DEPTH-2];
  assign scl_old   = scl_sr[DEPTH-1];
  assign sda_s     = sda_sr[DEPTH-2];
  assign sda_old   = sda_sr[DEPTH-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import synth_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [6:0] dev_addr,
  input  logic [7:0] status,
  output logic       sda_oe,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rd_session
);
  slv_state_t state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw_q, ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      rw_q       <= 1'b0;
      ack_q      <= 1'b0;
      sda_oe     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rd_session <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start_evt) begin
        state      <= S_ADDR;
        cnt        <= '0;
        sda_oe     <= 1'b0;
        rd_session <= 1'b0;
      end else if (stop_evt) begin
        state      <= S_IDLE;
        sda_oe     <= 1'b0;
        rd_session <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (shreg[7:1] == dev_addr) begin
                state  <= S_ADDR_ACK;
                sda_oe <= 1'b1;
                rw_q   <= shreg[0];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw_q) begin
                state      <= S_RD;
                shreg      <= status;
                sda_oe     <= ~status[7];
                rd_session <= 1'b1;
              end else begin
                state  <= S_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              rx_valid <= 1'b1;
              rx_data  <= shreg;
              sda_oe   <= 1'b1;
              state    <= S_WR_ACK;
            end
          end
          S_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                state  <= S_RD_ACK;
                sda_oe <= 1'b0;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                sda_oe <= ~shreg[6];
              end
            end
          end
          S_RD_ACK: begin
            if (scl_rise) begin
              ack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_q) begin
                state  <= S_RD;
                cnt    <= '0;
                shreg  <= status;
                sda_oe <= ~status[7];
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  addr_miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && cnt == 4'd8 && shreg[7:1] != dev_addr
     && !start_evt && !stop_evt) |=> (!sda_oe && state == S_IDLE));

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_ACK && scl_fall && !ack_q && !start_evt && !stop_evt)
      |=> (state == S_IDLE && !sda_oe));

  // R6
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && state == S_ADDR));
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_ctl_pkg::*;
#(
  parameter int RATIO_W = 15,
  parameter int PORT_N  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               rd_session,
  input  logic               por_event,
  output logic [RATIO_W-1:0] div_ratio,
  output ctl_word_t          ctl,
  output logic [PORT_N-1:0]  port_en,
  output logic               por_flag
);
  localparam int HI_W = RATIO_W - 8;

  logic       second_q;
  logic [7:0] first_q;
  logic       unused_bits;

  assign unused_bits = ^rx_data[7:PORT_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_ratio <= '0;
      ctl       <= '0;
      port_en   <= '0;
      por_flag  <= 1'b1;
      second_q  <= 1'b0;
      first_q   <= '0;
    end else if (por_event) begin
      div_ratio <= '0;
      ctl       <= '0;
      port_en   <= '0;
      por_flag  <= 1'b1;
      second_q  <= 1'b0;
    end else begin
      if (stop_evt && rd_session) por_flag <= 1'b0;
      if (start_evt || stop_evt) begin
        second_q <= 1'b0;
      end else if (rx_valid) begin
        if (!second_q) begin
          first_q  <= rx_data;
          second_q <= 1'b1;
          if (rx_data[7]) ctl <= rx_data[6:0];
        end else begin
          second_q <= 1'b0;
          if (first_q[7]) port_en   <= rx_data[PORT_N-1:0];
          else            div_ratio <= {first_q[HI_W-1:0], rx_data};
        end
      end
    end
  end

  // R11
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_event |=> (por_flag && div_ratio == '0 && port_en == '0 && ctl == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !por_event) |=> ($stable(div_ratio) && $stable(port_en) && $stable(ctl)));

  // R10
  por_read_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && rd_session && !por_event) |=> !por_flag);
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
  import synth_ctl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr_sel,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        lock_i,
  input  logic [2:0]  port_lvl,
  input  logic [2:0]  adc_code,
  input  logic        por_event,
  output logic [14:0] div_ratio,
  output logic        cp_hi,
  output logic        test_en,
  output logic        pump_off,
  output logic [2:0]  test_sel,
  output logic        amp_off,
  output logic [4:0]  port_en
);
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       rx_valid, rd_session, por_flag;
  logic [7:0] rx_data, status;
  ctl_word_t  ctl;

  assign status = {por_flag, lock_i, port_lvl, adc_code};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_slave_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .dev_addr({ADDR_PREFIX, addr_sel}), .status(status),
    .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_session(rd_session)
  );

  synth_reg_bank #(.RATIO_W(15), .PORT_N(5)) u_regs (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_session(rd_session),
    .por_event(por_event), .div_ratio(div_ratio), .ctl(ctl),
    .port_en(port_en), .por_flag(por_flag)
  );

  assign cp_hi    = ctl.cp;
  assign test_en  = ctl.t1;
  assign pump_off = ctl.t0;
  assign test_sel = ctl.ts;
  assign amp_off  = ctl.os;
endmodule

// File: tb/synth_ctl_i2c_test.sv
module synth_ctl_i2c_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic lock_i = 1'b0, por_event = 1'b0;
  logic [2:0] port_lvl = 3'b000, adc_code = 3'b000;
  wire  sda_line;
  logic sda_oe;
  logic [14:0] div_ratio;
  logic cp_hi, test_en, pump_off, amp_off;
  logic [2:0] test_sel;
  logic [4:0] port_en;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got;
  event got_ev;

  assign sda_line = !(m_sda_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_ctl_i2c #(.SYNC_STAGES(3)) uut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(m_scl),
    .sda_i(sda_line), .sda_oe(sda_oe), .lock_i(lock_i), .port_lvl(port_lvl),
    .adc_code(adc_code), .por_event(por_event), .div_ratio(div_ratio),
    .cp_hi(cp_hi), .test_en(test_en), .pump_off(pump_off), .test_sel(test_sel),
    .amp_off(amp_off), .port_en(port_en)
  );

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda_low = 1'b0; m_scl = 1'b1; wt(Q);
    m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    m_scl = 1'b0; m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda_low = 1'b0; wt(Q);
  endtask

  task automatic send_bit(logic b);
    m_sda_low = !b; wt(Q);
    m_scl = 1'b1; wt(2*Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda_low = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic wr_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(logic give_ack);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!give_ack);
    m_sda_low = 1'b0;
    got = v;
    -> got_ev;
    wt(1);
  endtask

  task automatic expect_rd(logic [7:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected read", {24'd0, got}, 32'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, {24'd0, got}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    wt(5);
    rst_n = 1'b1;
    wt(5);
    // R1 reset state
    chk(div_ratio == 15'd0, "R1 div_ratio", {17'd0, div_ratio}, 32'd0);
    chk({cp_hi, test_en, pump_off, test_sel, amp_off} == 7'd0, "R1 ctl",
        {25'd0, cp_hi, test_en, pump_off, test_sel, amp_off}, 32'd0);
    chk(port_en == 5'd0 && !sda_oe, "R1 port_en/sda_oe", {26'd0, sda_oe, port_en}, 32'd0);

    // R2 R3 R4 R5 R6: streamed pairs in one write
    i2c_start();
    wr_byte(8'hC0, a); chk(a, "R2 address ack", a, 1);
    wr_byte(8'h12, a); chk(a, "R6 data ack", a, 1);
    wr_byte(8'h34, a); chk(a, "R6 data ack", a, 1);
    wt(4);
    chk(div_ratio == 15'h1234, "R3 freq pair", {17'd0, div_ratio}, 32'h1234);
    wr_byte(8'hC5, a);
    wt(4);
    chk({cp_hi, test_en, pump_off, test_sel, amp_off} == 7'b1000101, "R4 ctl byte",
        {25'd0, cp_hi, test_en, pump_off, test_sel, amp_off}, 32'h45);
    chk(div_ratio == 15'h1234, "R3 ctl leaves ratio", {17'd0, div_ratio}, 32'h1234);
    wr_byte(8'h15, a);
    wr_byte(8'h7F, a);
    wr_byte(8'hFF, a); chk(a, "R6 streamed ack", a, 1);
    i2c_stop();
    chk(port_en == 5'h15, "R5 port byte", {27'd0, port_en}, 32'h15);
    chk(div_ratio == 15'h7FFF, "R6 second freq pair", {17'd0, div_ratio}, 32'h7FFF);
    chk({cp_hi, test_en, pump_off, test_sel, amp_off} == 7'b1000101, "R3 freq leaves ctl",
        {25'd0, cp_hi, test_en, pump_off, test_sel, amp_off}, 32'h45);

    // R2 wrong address
    i2c_start();
    wr_byte(8'hC2, a); chk(!a, "R2 mismatch no ack", a, 0);
    wr_byte(8'h00, a); chk(!a, "R2 mismatch data ignored", a, 0);
    wr_byte(8'h00, a);
    i2c_stop();
    chk(div_ratio == 15'h7FFF, "R2 mismatch no write", {17'd0, div_ratio}, 32'h7FFF);

    // R7 abort mid-byte
    i2c_start();
    wr_byte(8'hC0, a);
    wr_byte(8'h01, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_stop();
    chk(div_ratio == 15'h7FFF, "R7 aborted byte", {17'd0, div_ratio}, 32'h7FFF);
    i2c_start();
    wr_byte(8'hC0, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    i2c_stop();
    chk({cp_hi, test_en, pump_off, test_sel, amp_off} == 7'b1000101 && port_en == 5'h15,
        "R7 aborted ctl byte", {20'd0, cp_hi, test_en, pump_off, test_sel, amp_off, port_en},
        {20'd0, 7'b1000101, 5'h15});

    // R8 R9 R10 read with repeats, POR still set after write STOPs
    lock_i = 1'b1; port_lvl = 3'b101; adc_code = 3'b011;
    expect_rd(8'hEB, "R10 POR survives write stop / R9 layout");
    expect_rd(8'hEB, "R8 repeat after ack");
    expect_rd(8'hEB, "R8 repeat after second ack");
    expect_rd(8'hFF, "R8 released after nack");
    i2c_start();
    wr_byte(8'hC1, a); chk(a, "R2 read address ack", a, 1);
    rd_byte(1'b1);
    rd_byte(1'b1);
    rd_byte(1'b0);
    rd_byte(1'b0);
    i2c_stop();

    // R10 POR cleared by read stop; R9 other pattern
    lock_i = 1'b0; port_lvl = 3'b010; adc_code = 3'b100;
    expect_rd(8'h14, "R10 POR cleared / R9 layout");
    i2c_start();
    wr_byte(8'hC1, a);
    rd_byte(1'b0);
    i2c_stop();

    // R11 por_event
    @(negedge clk); por_event = 1'b1;
    @(negedge clk); por_event = 1'b0;
    wt(2);
    chk(div_ratio == 15'd0 && port_en == 5'd0, "R11 regs cleared",
        {12'd0, div_ratio, port_en}, 32'd0);
    chk({cp_hi, test_en, pump_off, test_sel, amp_off} == 7'd0, "R11 ctl cleared",
        {25'd0, cp_hi, test_en, pump_off, test_sel, amp_off}, 32'd0);
    expect_rd(8'h94, "R11 POR set again");
    i2c_start();
    wr_byte(8'hC1, a);
    rd_byte(1'b0);
    i2c_stop();

    // R2 other address select
    addr_sel = 2'b10;
    wt(4);
    i2c_start();
    wr_byte(8'hC0, a); chk(!a, "R2 old address refused", a, 0);
    i2c_stop();
    i2c_start();
    wr_byte(8'hC4, a); chk(a, "R2 new address ack", a, 1);
    wr_byte(8'h00, a);
    wr_byte(8'h05, a);
    i2c_stop();
    chk(div_ratio == 15'h0005, "R3 write at new address", {17'd0, div_ratio}, 32'h5);

    wt(20);
    chk(exp_q.size() == 0, "R8 all reads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule